// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block holds a processor's on-chip configuration registers behind a pair of byte-wide I/O ports. Software first writes an 8-bit register index to the index port and then makes exactly one read or write at the data port. That one data access goes to the selected register, and the index is then spent. Any later data access without a fresh index reads 0xFF and drops its write.

The register space is sparse. It has eight control bytes, a set of three-byte region descriptors, and two read-only identification bytes. The upper four bits of one control byte act as an unlock key. They decide whether the extended control bytes and the region descriptors are visible at all. Every decoded byte is driven out continuously as configuration outputs for the rest of the chip. Reads return their byte on a registered output one cycle after the access.

Top module: `cfg_index_port`

## Requirements
- R1: After reset all control and region bytes are 0x00, so `ctrlOut` and `regionOut` are all zero, and no index is held: a data-port read returns 0xFF.
- R2: An I/O write to address 0x22 latches the index. A following write at address 0x23 stores the byte into the selected implemented register. The control bytes at indices 0xC0..0xC3 appear on `ctrlOut` bytes 0..3, and those at 0xE8..0xEB appear on bytes 4..7 (byte k at bits 8k+7:8k). A following read at 0x23 returns the stored byte.
- R3: Exactly one data-port access (read or write) consumes the index. A second data access without a new index write reads 0xFF and its write changes nothing.
- R4: Any index outside the implemented map reads 0xFF, and a write to it changes no register.
- R5: Indices 0xFE and 0xFF read the parameter values `ID_LO` and `ID_HI`, and writes to them are ignored.
- R6: The extended group is visible only while bits 7:4 of the byte at 0xC3 equal `MAP_KEY` (default 4'h1). The extended group is indices 0xE8..0xEB plus all region bytes. While the group is hidden its indices read 0xFF and ignore writes. Indices 0xC0..0xC3 and the identification bytes are always visible.
- R7: Region descriptor r takes three consecutive indices starting at 0xC4+3r, each written as its own byte. On `regionOut[24r+23:24r]` it appears as {byte at 0xC4+3r, byte at 0xC5+3r, byte at 0xC6+3r}.
- R8: `ioRdata` and `ioRdValid` update on the clock edge that samples a read access. `ioRdValid` is high for that one cycle only.
- R9: A read of the index port returns 0xFF and leaves the held index valid. Accesses to any other I/O address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioStrobe | input | 1 | One-cycle I/O access request |
| ioWrite | input | 1 | 1 = write access, 0 = read access |
| ioAddr | input | 16 | I/O address of the access |
| ioWdata | input | 8 | Write data |
| ioRdata | output | 8 | Read data, registered |
| ioRdValid | output | 1 | One-cycle pulse marking `ioRdata` as fresh |
| ctrlOut | output | 64 | Eight control bytes |
| regionOut | output | 96 | Four 24-bit region descriptors |

## Verification
The assertions assume that each cycle carries at most one access and that `ioStrobe`, `ioWrite` and `ioAddr` are known and held for the whole cycle. Under those assumptions an index-port access and a data-port access can never occur in the same cycle. The bench drives every access as a single-cycle strobe set up on the falling edge, followed by an idle cycle. This keeps it within that assumption while it sweeps all 256 indices, once with the extended group hidden and once with it unlocked.

// File: rtl/cfg_index_pkg.sv
package cfg_index_pkg;
  localparam int SLOT_W   = 5;
  localparam int NUM_CTRL = 8;
  localparam int MAP_SLOT = 3;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_CTRL   = 2'd1,
    SEL_REGION = 2'd2,
    SEL_ID     = 2'd3
  } sel_e;

  typedef struct packed {
    logic              wr;
    logic              rd;
    sel_e              sel;
    logic [SLOT_W-1:0] slot;
  } strobe_t;
endpackage

// File: rtl/cfg_index_ctrl.sv
module cfg_index_ctrl
  import cfg_index_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int INDEX_PORT   = 'h22,
  parameter int DATA_PORT    = 'h23,
  parameter int CTRL_LO_BASE = 'hC0,
  parameter int CTRL_HI_BASE = 'hE8,
  parameter int REGION_BASE  = 'hC4,
  parameter int NUM_REGIONS  = 4,
  parameter int ID_BASE      = 'hFE,
  parameter logic [3:0] MAP_KEY = 4'h1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioStrobe,
  input  logic              ioWrite,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [7:0]        ioWdata,
  input  logic [3:0]        mapField,
  output strobe_t           stb
);
  localparam int HALF_CTRL    = NUM_CTRL / 2;
  localparam int REGION_BYTES = 3 * NUM_REGIONS;

  logic [7:0] curIdx;
  logic       idxValid;
  logic       hitIndex;
  logic       hitData;
  logic       unlocked;
  sel_e       decSel;
  logic [SLOT_W-1:0] decSlot;

  assign hitIndex = ioStrobe && (ioAddr == ADDR_W'(INDEX_PORT));
  assign hitData  = ioStrobe && (ioAddr == ADDR_W'(DATA_PORT));
  assign unlocked = (mapField == MAP_KEY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx   <= '0;
      idxValid <= 1'b0;
    end else if (hitIndex && ioWrite) begin
      curIdx   <= ioWdata;
      idxValid <= 1'b1;
    end else if (hitData) begin
      idxValid <= 1'b0;
    end
  end

  always_comb begin
    decSel  = SEL_NONE;
    decSlot = '0;
    if (int'(curIdx) >= CTRL_LO_BASE && int'(curIdx) < CTRL_LO_BASE + HALF_CTRL) begin
      decSel  = SEL_CTRL;
      decSlot = SLOT_W'(int'(curIdx) - CTRL_LO_BASE);
    end else if (unlocked && int'(curIdx) >= CTRL_HI_BASE &&
                 int'(curIdx) < CTRL_HI_BASE + HALF_CTRL) begin
      decSel  = SEL_CTRL;
      decSlot = SLOT_W'(int'(curIdx) - CTRL_HI_BASE + HALF_CTRL);
    end else if (unlocked && int'(curIdx) >= REGION_BASE &&
                 int'(curIdx) < REGION_BASE + REGION_BYTES) begin
      decSel  = SEL_REGION;
      decSlot = SLOT_W'(int'(curIdx) - REGION_BASE);
    end else if (int'(curIdx) == ID_BASE || int'(curIdx) == ID_BASE + 1) begin
      decSel  = SEL_ID;
      decSlot = SLOT_W'(int'(curIdx) - ID_BASE);
    end
  end

  always_comb begin
    stb.wr   = hitData && ioWrite && idxValid;
    stb.rd   = ioStrobe && !ioWrite && (hitData || hitIndex);
    stb.sel  = (hitData && idxValid) ? decSel : SEL_NONE;
    stb.slot = (hitData && idxValid) ? decSlot : '0;
  end

  // R2: an index write is held for the next data access
  assert_index_latch_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hitIndex && ioWrite) |=> (idxValid && curIdx == $past(ioWdata)));

  // R3: one data access spends the index
  assert_index_consumed_R3: assert property (@(posedge clk) disable iff (!rstN)
    hitData |=> !idxValid);

  // R9: reading the index port disturbs nothing
  assert_index_read_keeps_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hitIndex && !ioWrite) |=> (idxValid == $past(idxValid) && curIdx == $past(curIdx)));
endmodule

// File: rtl/cfg_index_regs.sv
module cfg_index_regs
  import cfg_index_pkg::*;
#(
  parameter int NUM_REGIONS   = 4,
  parameter logic [7:0] ID_LO = 8'h3A,
  parameter logic [7:0] ID_HI = 8'h05
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   stb,
  input  logic [7:0]                wrData,
  output logic [7:0]                rdData,
  output logic                      rdValid,
  output logic [3:0]                mapField,
  output logic [NUM_CTRL*8-1:0]     ctrlOut,
  output logic [NUM_REGIONS*24-1:0] regionOut
);
  localparam int REGION_BYTES = 3 * NUM_REGIONS;

  logic [7:0] ctrlReg   [NUM_CTRL];
  logic [7:0] regionByte[REGION_BYTES];
  logic [7:0] rdNext;

  for (genvar g = 0; g < NUM_CTRL; g++) begin : gCtrl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        ctrlReg[g] <= '0;
      else if (stb.wr && stb.sel == SEL_CTRL && stb.slot == SLOT_W'(g))
        ctrlReg[g] <= wrData;
    end
    assign ctrlOut[8*g +: 8] = ctrlReg[g];
  end

  for (genvar b = 0; b < REGION_BYTES; b++) begin : gRegionByte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regionByte[b] <= '0;
      else if (stb.wr && stb.sel == SEL_REGION && stb.slot == SLOT_W'(b))
        regionByte[b] <= wrData;
    end
  end

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : gRegionOut
    assign regionOut[24*r +: 24] = {regionByte[3*r], regionByte[3*r+1], regionByte[3*r+2]};
  end

  assign mapField = ctrlReg[MAP_SLOT][7:4];

  always_comb begin
    rdNext = 8'hFF;
    case (stb.sel)
      SEL_CTRL:
        for (int k = 0; k < NUM_CTRL; k++)
          if (stb.slot == SLOT_W'(k)) rdNext = ctrlReg[k];
      SEL_REGION:
        for (int k = 0; k < REGION_BYTES; k++)
          if (stb.slot == SLOT_W'(k)) rdNext = regionByte[k];
      SEL_ID:
        rdNext = stb.slot[0] ? ID_HI : ID_LO;
      default:
        rdNext = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= 8'hFF;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.rd;
      if (stb.rd) rdData <= rdNext;
    end
  end

  // R4: a read that selects nothing returns all ones
  assert_unmapped_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rd && stb.sel == SEL_NONE) |=> rdData == 8'hFF);

  // R5: identification bytes read back their fixed values
  assert_id_value_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rd && stb.sel == SEL_ID) |=> (rdData == ($past(stb.slot[0]) ? ID_HI : ID_LO)));

  // R8: the valid flag only follows a read access
  assert_rdvalid_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(stb.rd));

  // R2: control bytes change only on a control write
  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wr && stb.sel == SEL_CTRL) |=> $stable(ctrlOut));

  // R7: region bytes change only on a region write
  assert_region_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wr && stb.sel == SEL_REGION) |=> $stable(regionOut));
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfg_index_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int NUM_REGIONS   = 4,
  parameter logic [7:0] ID_LO = 8'h3A,
  parameter logic [7:0] ID_HI = 8'h05,
  parameter logic [3:0] MAP_KEY = 4'h1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      ioStrobe,
  input  logic                      ioWrite,
  input  logic [ADDR_W-1:0]         ioAddr,
  input  logic [7:0]                ioWdata,
  output logic [7:0]                ioRdata,
  output logic                      ioRdValid,
  output logic [NUM_CTRL*8-1:0]     ctrlOut,
  output logic [NUM_REGIONS*24-1:0] regionOut
);
  strobe_t    stb;
  logic [3:0] mapField;

  cfg_index_ctrl #(
    .ADDR_W(ADDR_W),
    .NUM_REGIONS(NUM_REGIONS),
    .MAP_KEY(MAP_KEY)
  ) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .ioStrobe(ioStrobe),
    .ioWrite(ioWrite),
    .ioAddr(ioAddr),
    .ioWdata(ioWdata),
    .mapField(mapField),
    .stb(stb)
  );

  cfg_index_regs #(
    .NUM_REGIONS(NUM_REGIONS),
    .ID_LO(ID_LO),
    .ID_HI(ID_HI)
  ) uRegs (
    .clk(clk),
    .rstN(rstN),
    .stb(stb),
    .wrData(ioWdata),
    .rdData(ioRdata),
    .rdValid(ioRdValid),
    .mapField(mapField),
    .ctrlOut(ctrlOut),
    .regionOut(regionOut)
  );
endmodule

// File: tb/sim_cfg_index_port.sv
module sim_cfg_index_port;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 4;
  localparam logic [7:0] IDL = 8'h3A;
  localparam logic [7:0] IDH = 8'h05;
  localparam logic [15:0] PIDX = 16'h0022;
  localparam logic [15:0] PDAT = 16'h0023;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ioStrobe = 1'b0;
  logic ioWrite = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0] ioWdata = '0;
  logic [7:0] ioRdata;
  logic ioRdValid;
  logic [63:0] ctrlOut;
  logic [NREG*24-1:0] regionOut;

  int total = 0;
  int bad = 0;
  logic [7:0] model [256];
  logic unlockedM = 1'b0;
  logic [7:0] gotData;
  logic gotValid;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_index_port #(.NUM_REGIONS(NREG), .ID_LO(IDL), .ID_HI(IDH)) u0 (
    .clk(clk), .rstN(rstN), .ioStrobe(ioStrobe), .ioWrite(ioWrite),
    .ioAddr(ioAddr), .ioWdata(ioWdata), .ioRdata(ioRdata),
    .ioRdValid(ioRdValid), .ctrlOut(ctrlOut), .regionOut(regionOut)
  );

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic bit isCtrl(int i);
    return (i >= 'hC0 && i <= 'hC3) || (unlockedM && i >= 'hE8 && i <= 'hEB);
  endfunction
  function automatic bit isRegion(int i);
    return unlockedM && i >= 'hC4 && i < 'hC4 + 3*NREG;
  endfunction
  function automatic logic [7:0] expRead(int i);
    if (i == 'hFE) return IDL;
    if (i == 'hFF) return IDH;
    if (isCtrl(i) || isRegion(i)) return model[i];
    return 8'hFF;
  endfunction

  task automatic access(input logic w, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioStrobe = 1'b1; ioWrite = w; ioAddr = a; ioWdata = d;
    @(negedge clk);
    ioStrobe = 1'b0; ioWrite = 1'b0;
    gotData = ioRdata; gotValid = ioRdValid;
  endtask

  task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input int i, input logic [7:0] v);
    access(1'b1, PIDX, 8'(i));
    access(1'b1, PDAT, v);
    if (isCtrl(i) || isRegion(i)) model[i] = v;
    if (i == 'hC3) unlockedM = (v[7:4] == 4'h1);
  endtask

  task automatic readCheck(input int i, input string tag);
    access(1'b1, PIDX, 8'(i));
    access(1'b0, PDAT, 8'h00);
    check(tag, 96'(gotData), 96'(expRead(i)));
  endtask

  task automatic checkOutputs(input string tag);
    logic [63:0] ec;
    logic [NREG*24-1:0] er;
    for (int k = 0; k < 4; k++) begin
      ec[8*k +: 8] = model['hC0 + k];
      ec[8*(k+4) +: 8] = model['hE8 + k];
    end
    for (int r = 0; r < NREG; r++)
      er[24*r +: 24] = {model['hC4+3*r], model['hC5+3*r], model['hC6+3*r]};
    check({tag, " ctrlOut"}, 96'(ctrlOut), 96'(ec));
    check({tag, " regionOut"}, 96'(regionOut), 96'(er));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    checkOutputs("R1 reset");
    access(1'b0, PDAT, 8'h00);
    check("R1 no index after reset", 96'(gotData), 96'hFF);
    check("R8 valid on read", 96'(gotValid), 96'h1);
    @(negedge clk);
    check("R8 valid drops", 96'(ioRdValid), 96'h0);

    // R4 R5 R6: locked sweep
    for (int i = 0; i < 256; i++)
      if (i != 'hC3) writeReg(i, 8'(i) ^ 8'h5A);
    for (int i = 0; i < 256; i++) readCheck(i, "R4/R5/R6 locked sweep");
    checkOutputs("R6 locked outputs");

    // R6: unlock and sweep again, R2 R7
    writeReg('hC3, 8'h10);
    readCheck('hC3, "R6 key byte");
    for (int i = 0; i < 256; i++)
      if (i != 'hC3) writeReg(i, 8'(i * 7 + 3));
    for (int i = 0; i < 256; i++) readCheck(i, "R2/R4/R5/R7 unlocked sweep");
    checkOutputs("R2/R7 unlocked outputs");

    // R3: index consumed by a write
    writeReg('hC0, 8'hAA);
    access(1'b1, PDAT, 8'h55);
    readCheck('hC0, "R3 second write dropped");
    access(1'b1, PIDX, 8'hC1);
    access(1'b0, PDAT, 8'h00);
    check("R3 first read", 96'(gotData), 96'(model['hC1]));
    access(1'b0, PDAT, 8'h00);
    check("R3 second read", 96'(gotData), 96'hFF);

    // R9: index-port read and foreign addresses
    access(1'b1, PIDX, 8'hC2);
    access(1'b0, PIDX, 8'h00);
    check("R9 index port read", 96'(gotData), 96'hFF);
    access(1'b1, 16'h0024, 8'h77);
    access(1'b1, 16'h0122, 8'hE9);
    access(1'b0, PDAT, 8'h00);
    check("R9 index kept", 96'(gotData), 96'(model['hC2]));
    checkOutputs("R9 no side effect");

    // R6: relock, hidden writes dropped
    writeReg('hC3, 8'h20);
    readCheck('hE9, "R6 relocked read");
    readCheck('hC5, "R6 relocked region read");
    writeReg('hE9, 8'h99);
    writeReg('hC5, 8'h66);
    checkOutputs("R6 relocked writes dropped");
    writeReg('hC3, 8'h1F);
    readCheck('hE9, "R6 value kept while hidden");
    readCheck('hC5, "R7 region byte kept while hidden");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule